// File: doc/BRIEF.md
# Narrow-Access Write Combiner Bridge

This bridge connects a host that issues 8-, 16- and 32-bit register accesses to a register file that only takes aligned 32-bit reads and writes. A narrow write becomes a read of the containing word, a lane merge and a full-word write back. A narrow read fetches the word and returns the addressed lane, zero-extended.

Two 16-bit register groups get special handling. Writes to the block word (size and count halves) and to the transfer-mode half of the command word are held in shadow copies. They reach the register file only when the command half is written. At that point the pending block word and then the command word go out as two consecutive 32-bit writes. While a shadow is valid, 16-bit reads of its registers are served from the copy.

After each downstream write, if the card clock is slow, the bridge stalls for a fixed number of card-clock periods before it finishes the access. The host side carries one access at a time. An access is accepted on valid/ready and completes with a one-cycle response pulse.

Top module: `narrow_reg_bridge`

## Requirements
- R1: After reset, `host_ready` is 1, `resp_valid` is 0, no downstream access is driven, and both shadow-valid flags are clear.
- R2: Size code 0 is one byte, 1 is two bytes, 2 (and 3) is four bytes. A narrow access uses lane shift = (address bits [1:0]) x 8, and every downstream address is the byte address with bits [1:0] cleared. A byte write reads the word, replaces only the addressed byte and writes the whole word back in one downstream write.
- R3: A narrow read returns the addressed lane of the downstream word, shifted to bit 0 and zero-extended.
- R4: A 32-bit read or write passes through unchanged as one downstream access, and the low address bits are ignored.
- R5: A 16-bit write to any register outside the block word, transfer mode (0x0C) and command (0x0E) is a read-modify-write of its word, with exactly one downstream write.
- R6: A 16-bit write to block size (0x04) or block count (0x06) makes no downstream write. It merges into the block shadow and sets its flag. The merge base is a fresh downstream read when the flag is clear and the shadow itself when the flag is set.
- R7: A 16-bit write to transfer mode (0x0C) reads word 0x0C, merges the value into the low half, stores the result in the command shadow and sets its flag, with no downstream write.
- R8: A 16-bit read of 0x04/0x06 while the block flag is set, or of 0x0C while the command flag is set, returns the shadow lane. Byte reads always go downstream.
- R9: A 16-bit write to command (0x0E) first writes a valid block shadow to 0x04 and clears its flag. It then writes the command word to 0x0C on the very next downstream slot and clears the command flag.
- R10: The command word is the command value in the upper half over the lower half of the command shadow, whether or not the command flag is set. The command write does not change the shadow.
- R11: When `card_khz` is nonzero and at most 400, each downstream write is followed by ceil(4 x SYS_KHZ / card_khz) stall cycles. That is 500 cycles at 400 kHz and 2000 at 100 kHz with a 50 MHz system clock. Otherwise there is no stall, and the response or next write follows the write in the next cycle.
- R12: `host_ready` is low from acceptance until the response, and each access produces exactly one single-cycle `resp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Bridge can accept an access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Byte address |
| host_size | input | 2 | 0 = byte, 1 = half, 2 = word |
| host_wdata | input | DW | Write data, right-aligned |
| resp_valid | output | 1 | Access complete (one cycle) |
| resp_rdata | output | DW | Read data, right-aligned, zero-extended |
| card_khz | input | CLK_W | Static card clock frequency in kHz |
| reg_en | output | 1 | Downstream access strobe |
| reg_we | output | 1 | Downstream write enable |
| reg_addr | output | AW | Downstream word-aligned byte address |
| reg_wdata | output | DW | Downstream write data |
| reg_rdata | input | DW | Downstream read data, one cycle after a read strobe |

## Verification
The bench changes the register file behind the bridge's back between shadowed writes. A design that merged the second block half into a fresh read, or served shadowed reads from the register file, would return the injected value instead of the held one. After a transfer-mode write followed by two command writes, a design that rebuilt the command word from the register file would lose the held mode bits. The bench also measures the exact cycle gap between the flushed block write and the command write, and between each write and the response, at 400 kHz, at 100 kHz, at 401 kHz and at zero. A miscounted stall or a split flush shows up there as a wrong number.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DISP, S_RD, S_RDATA, S_WR, S_SETTLE, S_RESP
  } state_e;

  typedef enum logic [2:0] {
    K_READ, K_PLAIN, K_BLK, K_XFER, K_CMD
  } kind_e;
endpackage

// File: rtl/nrb_lane_unit.sv
module nrb_lane_unit
  import nrb_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic [DW-1:0] base,
  input  logic [LW-1:0] lo,
  input  size_e         size,
  input  logic [DW-1:0] wval,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] lane
);
  localparam int SW = LW + 3;

  logic [LW-1:0] lo_eff;
  logic [LW:0]   nbytes;
  logic [LW:0]   first;
  logic [LW:0]   last_ex;
  logic [SW-1:0] shamt;
  logic [DW-1:0] fmask;
  logic [DW-1:0] wsh;

  always_comb begin
    lo_eff = (size == SZ_WORD) ? '0 : lo;
    case (size)
      SZ_BYTE: begin nbytes = (LW+1)'(1); fmask = DW'(8'hFF);    end
      SZ_HALF: begin nbytes = (LW+1)'(2); fmask = DW'(16'hFFFF); end
      default: begin nbytes = (LW+1)'(NB); fmask = '1;           end
    endcase
    first   = {1'b0, lo_eff};
    last_ex = first + nbytes;
    shamt   = {lo_eff, 3'b000};
    wsh     = wval << shamt;
    lane    = (base >> shamt) & fmask;
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic hit;
    assign hit = ((LW+1)'(i) >= first) && ((LW+1)'(i) < last_ex);
    assign merged[8*i +: 8] = hit ? wsh[8*i +: 8] : base[8*i +: 8];
  end
endmodule

// File: rtl/nrb_shadow.sv
module nrb_shadow #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_blk,
  input  logic          ld_cmd,
  input  logic          clr_blk,
  input  logic          clr_cmd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] blk_q,
  output logic [DW-1:0] cmd_q,
  output logic          blk_v,
  output logic          cmd_v
);
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= '0;
      cmd_q <= '0;
      blk_v <= 1'b0;
      cmd_v <= 1'b0;
    end else begin
      if (ld_blk) begin
        blk_q <= din;
        blk_v <= 1'b1;
      end else if (clr_blk) begin
        blk_v <= 1'b0;
      end
      if (ld_cmd) begin
        cmd_q <= din;
        cmd_v <= 1'b1;
      end else if (clr_cmd) begin
        cmd_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nrb_settle.sv
module nrb_settle #(
  parameter int SYS_KHZ     = 50000,
  parameter int SLOW_KHZ    = 400,
  parameter int SETTLE_CLKS = 4,
  parameter int CLK_W       = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CLK_W-1:0] card_khz,
  output logic             slow,
  output logic             done
);
  localparam int TARGET = SETTLE_CLKS * SYS_KHZ;
  localparam int ACC_W  = $clog2(TARGET + SLOW_KHZ + 1);

  logic             counting;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc_nxt;

  assign slow    = (card_khz != '0) && (card_khz <= CLK_W'(SLOW_KHZ));
  assign step    = ACC_W'(card_khz);
  assign acc_nxt = acc + step;
  assign done    = counting && (acc_nxt >= ACC_W'(TARGET));

  always_ff @(posedge clk) begin
    if (rst) begin
      counting <= 1'b0;
      acc      <= '0;
    end else if (start) begin
      counting <= 1'b1;
      acc      <= '0;
    end else if (counting) begin
      acc <= acc_nxt;
      if (done) counting <= 1'b0;
    end
  end
endmodule

// File: rtl/narrow_reg_bridge.sv
module narrow_reg_bridge
  import nrb_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int CLK_W       = 20,
  parameter int SYS_KHZ     = 50000,
  parameter int SLOW_KHZ    = 400,
  parameter int SETTLE_CLKS = 4,
  parameter int BLK_OFS     = 4,
  parameter int XFER_OFS    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_write,
  input  logic [AW-1:0]    host_addr,
  input  logic [1:0]       host_size,
  input  logic [DW-1:0]    host_wdata,
  output logic             resp_valid,
  output logic [DW-1:0]    resp_rdata,
  input  logic [CLK_W-1:0] card_khz,
  output logic             reg_en,
  output logic             reg_we,
  output logic [AW-1:0]    reg_addr,
  output logic [DW-1:0]    reg_wdata,
  input  logic [DW-1:0]    reg_rdata
);
  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);
  localparam logic [AW-1:0] BLK_A  = AW'(BLK_OFS);
  localparam logic [AW-1:0] XFER_A = AW'(XFER_OFS);
  localparam logic [AW-1:0] CMD_A  = AW'(XFER_OFS + 2);

  state_e        st;
  kind_e         kind;
  logic          flush_q;
  logic          cap_write;
  logic [AW-1:0] cap_addr;
  size_e         cap_size;
  logic [DW-1:0] cap_wdata;
  logic [DW-1:0] rdata_q;
  logic [AW-1:0] wr_addr_q;
  logic [DW-1:0] wr_data_q;

  logic [DW-1:0] blk_q, cmd_q;
  logic          blk_v, cmd_v;
  logic [DW-1:0] base, merged, lane;
  logic [AW-1:0] cap_word;
  logic          is_blk, is_xfer, is_cmd;
  logic          ld_blk, ld_cmd, clr_blk, clr_cmd;
  logic          slow, settle_done, settle_start, advance;

  assign cap_word = {cap_addr[AW-1:LW], {LW{1'b0}}};
  assign is_blk   = (cap_size == SZ_HALF) && (cap_addr[AW-1:LW] == BLK_A[AW-1:LW]);
  assign is_xfer  = (cap_size == SZ_HALF) && (cap_addr == XFER_A);
  assign is_cmd   = (cap_size == SZ_HALF) && (cap_addr == CMD_A);

  assign base = (st == S_RDATA) ? reg_rdata : (is_blk ? blk_q : cmd_q);

  nrb_lane_unit #(.DW(DW)) u_lane (
    .base   (base),
    .lo     (cap_addr[LW-1:0]),
    .size   (cap_size),
    .wval   (cap_wdata),
    .merged (merged),
    .lane   (lane)
  );

  assign ld_blk  = ((st == S_DISP) && cap_write && is_blk && blk_v) ||
                   ((st == S_RDATA) && (kind == K_BLK));
  assign ld_cmd  = (st == S_RDATA) && (kind == K_XFER);
  assign clr_blk = (st == S_WR) && (kind == K_CMD) && flush_q;
  assign clr_cmd = (st == S_WR) && (kind == K_CMD) && !flush_q;

  nrb_shadow #(.DW(DW)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .ld_blk  (ld_blk),
    .ld_cmd  (ld_cmd),
    .clr_blk (clr_blk),
    .clr_cmd (clr_cmd),
    .din     (merged),
    .blk_q   (blk_q),
    .cmd_q   (cmd_q),
    .blk_v   (blk_v),
    .cmd_v   (cmd_v)
  );

  assign settle_start = (st == S_WR) && slow;

  nrb_settle #(
    .SYS_KHZ     (SYS_KHZ),
    .SLOW_KHZ    (SLOW_KHZ),
    .SETTLE_CLKS (SETTLE_CLKS),
    .CLK_W       (CLK_W)
  ) u_settle (
    .clk      (clk),
    .rst      (rst),
    .start    (settle_start),
    .card_khz (card_khz),
    .slow     (slow),
    .done     (settle_done)
  );

  assign advance = ((st == S_WR) && !slow) || ((st == S_SETTLE) && settle_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      kind      <= K_READ;
      flush_q   <= 1'b0;
      cap_write <= 1'b0;
      cap_addr  <= '0;
      cap_size  <= SZ_BYTE;
      cap_wdata <= '0;
      rdata_q   <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (host_valid) begin
          cap_write <= host_write;
          cap_addr  <= host_addr;
          cap_wdata <= host_wdata;
          cap_size  <= (host_size == 2'd0) ? SZ_BYTE :
                       (host_size == 2'd1) ? SZ_HALF : SZ_WORD;
          flush_q   <= 1'b0;
          st        <= S_DISP;
        end
        S_DISP: begin
          if (!cap_write) begin
            kind <= K_READ;
            if ((is_blk && blk_v) || (is_xfer && cmd_v)) begin
              rdata_q <= lane;
              st      <= S_RESP;
            end else begin
              st <= S_RD;
            end
          end else begin
            rdata_q <= '0;
            if (cap_size == SZ_WORD) begin
              kind      <= K_PLAIN;
              wr_addr_q <= cap_word;
              wr_data_q <= cap_wdata;
              st        <= S_WR;
            end else if (is_blk) begin
              kind <= K_BLK;
              st   <= blk_v ? S_RESP : S_RD;
            end else if (is_xfer) begin
              kind <= K_XFER;
              st   <= S_RD;
            end else if (is_cmd) begin
              kind <= K_CMD;
              if (blk_v) begin
                flush_q   <= 1'b1;
                wr_addr_q <= {BLK_A[AW-1:LW], {LW{1'b0}}};
                wr_data_q <= blk_q;
              end else begin
                wr_addr_q <= XFER_A;
                wr_data_q <= merged;
              end
              st <= S_WR;
            end else begin
              kind <= K_PLAIN;
              st   <= S_RD;
            end
          end
        end
        S_RD: st <= S_RDATA;
        S_RDATA: begin
          case (kind)
            K_READ: begin rdata_q <= lane; st <= S_RESP; end
            K_BLK, K_XFER: st <= S_RESP;
            default: begin
              wr_addr_q <= cap_word;
              wr_data_q <= merged;
              st        <= S_WR;
            end
          endcase
        end
        S_WR, S_SETTLE: begin
          if (advance) begin
            if ((kind == K_CMD) && flush_q) begin
              flush_q   <= 1'b0;
              wr_addr_q <= XFER_A;
              wr_data_q <= merged;
              st        <= S_WR;
            end else begin
              st <= S_RESP;
            end
          end else if (st == S_WR) begin
            st <= S_SETTLE;
          end
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign host_ready = (st == S_IDLE);
  assign resp_valid = (st == S_RESP);
  assign resp_rdata = rdata_q;
  assign reg_en     = (st == S_RD) || (st == S_WR);
  assign reg_we     = (st == S_WR);
  assign reg_addr   = (st == S_RD) ? cap_word : wr_addr_q;
  assign reg_wdata  = wr_data_q;
endmodule

// File: rtl/nrb_checker.sv
module nrb_checker #(
  parameter int AW       = 8,
  parameter int CLK_W    = 20,
  parameter int SLOW_KHZ = 400
) (
  input logic             clk,
  input logic             rst,
  input logic             host_valid,
  input logic             host_ready,
  input logic             resp_valid,
  input logic             reg_en,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [CLK_W-1:0] card_khz
);
  logic slow_clk;
  assign slow_clk = (card_khz != '0) && (card_khz <= CLK_W'(SLOW_KHZ));

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (host_ready && !resp_valid && !reg_en));

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
    reg_en |-> (reg_addr[1:0] == 2'b00));

  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_ready) |=> !host_ready);

  a_r12_single_resp: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  a_r12_not_ready_busy: assert property (@(posedge clk) disable iff (rst)
    (reg_en || resp_valid) |-> !host_ready);

  a_r11_slow_stall: assert property (@(posedge clk) disable iff (rst)
    (reg_en && reg_we && slow_clk) |=> (!reg_en && !resp_valid));
endmodule

bind narrow_reg_bridge nrb_checker #(
  .AW       (AW),
  .CLK_W    (CLK_W),
  .SLOW_KHZ (SLOW_KHZ)
) u_nrb_checker (
  .clk        (clk),
  .rst        (rst),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .resp_valid (resp_valid),
  .reg_en     (reg_en),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .card_khz   (card_khz)
);

// File: tb/narrow_reg_bridge_test.sv
`timescale 1ns/1ps
module narrow_reg_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic [19:0] card_khz = 20'd25000;
  logic        reg_en, reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = '0;

  logic [31:0] mem [0:63];
  int cyc = 0, last_wr_cyc = 0, prev_wr_cyc = 0, wr_cnt = 0;
  int checks = 0, errors = 0, resp_cyc = 0;
  logic ready_at_resp;
  bit done = 1'b0;

  always #10 clk = ~clk;

  narrow_reg_bridge uut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_size(host_size),
    .host_wdata(host_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .card_khz(card_khz), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_en && reg_we) begin
      mem[reg_addr[7:2]] <= reg_wdata;
      prev_wr_cyc <= last_wr_cyc;
      last_wr_cyc <= cyc;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_en && !reg_we) reg_rdata <= mem[reg_addr[7:2]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = a; host_size = sz; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    q = resp_rdata;
    ready_at_resp = host_ready;
    resp_cyc = cyc;
  endtask

  task automatic wr_acc(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] q;
    access(1'b1, a, sz, d, q);
  endtask

  task automatic rd_acc(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] q);
    access(1'b0, a, sz, 32'h0, q);
  endtask

  task automatic t_reset();
    check("R1 ready", {31'b0, host_ready}, 32'd1);
    check("R1 resp", {31'b0, resp_valid}, 32'd0);
    check("R1 reg_en", {31'b0, reg_en}, 32'd0);
  endtask

  task automatic t_byte_write();
    int n0;
    mem[8] = 32'h11223344; n0 = wr_cnt;
    wr_acc(8'h22, 2'd0, 32'hFFFF_FFAB);
    check("R2 byte merge", mem[8], 32'h11AB3344);
    check("R2 one write", wr_cnt - n0, 1);
    check("R12 busy at resp", {31'b0, ready_at_resp}, 32'd0);
  endtask

  task automatic t_narrow_read();
    logic [31:0] q;
    rd_acc(8'h23, 2'd0, q); check("R3 byte lane3", q, 32'h11);
    rd_acc(8'h22, 2'd1, q); check("R3 half upper", q, 32'h11AB);
    rd_acc(8'h21, 2'd2, q); check("R4 word read", q, 32'h11AB3344);
  endtask

  task automatic t_word_write();
    int n0 = wr_cnt;
    wr_acc(8'h30, 2'd2, 32'hCAFEF00D);
    check("R4 word write", mem[12], 32'hCAFEF00D);
    check("R4 one write", wr_cnt - n0, 1);
  endtask

  task automatic t_half_other();
    int n0;
    mem[11] = 32'h99887766; n0 = wr_cnt;
    wr_acc(8'h2E, 2'd1, 32'h1357);
    check("R5 half rmw", mem[11], 32'h13577766);
    check("R5 one write", wr_cnt - n0, 1);
  endtask

  task automatic t_block();
    logic [31:0] q;
    int n0;
    mem[1] = 32'hDEADBEEF; n0 = wr_cnt;
    wr_acc(8'h04, 2'd1, 32'h0200);
    check("R6 no write", wr_cnt - n0, 0);
    check("R6 reg untouched", mem[1], 32'hDEADBEEF);
    mem[1] = 32'h55555555;
    wr_acc(8'h06, 2'd1, 32'h0003);
    check("R6 still no write", wr_cnt - n0, 0);
    rd_acc(8'h06, 2'd1, q); check("R8 count from shadow", q, 32'h0003);
    rd_acc(8'h04, 2'd1, q); check("R6 merged on shadow", q, 32'h0200);
    rd_acc(8'h04, 2'd0, q); check("R8 byte read downstream", q, 32'h55);
  endtask

  task automatic t_xfer();
    logic [31:0] q;
    int n0;
    mem[3] = 32'hA5A50000; n0 = wr_cnt;
    wr_acc(8'h0C, 2'd1, 32'h0023);
    check("R7 no write", wr_cnt - n0, 0);
    check("R7 reg untouched", mem[3], 32'hA5A50000);
    mem[3] = 32'h77770000;
    rd_acc(8'h0C, 2'd1, q); check("R8 mode from shadow", q, 32'h0023);
  endtask

  task automatic t_cmd_flush();
    logic [31:0] q;
    int n0 = wr_cnt;
    wr_acc(8'h0E, 2'd1, 32'h113A);
    check("R9 two writes", wr_cnt - n0, 2);
    check("R9 block word", mem[1], 32'h00030200);
    check("R9 command word", mem[3], 32'h113A0023);
    check("R9 back to back", last_wr_cyc - prev_wr_cyc, 1);
    check("R11 fast resp", resp_cyc - last_wr_cyc, 1);
    mem[1] = 32'h00000BAD; mem[3] = 32'h00004444;
    rd_acc(8'h04, 2'd1, q); check("R9 block flag cleared", q, 32'h0BAD);
    rd_acc(8'h0C, 2'd1, q); check("R9 cmd flag cleared", q, 32'h4444);
  endtask

  task automatic t_stale_cmd();
    int n0 = wr_cnt;
    wr_acc(8'h0E, 2'd1, 32'h1234);
    check("R10 single write", wr_cnt - n0, 1);
    check("R10 mode from shadow", mem[3], 32'h12340023);
  endtask

  task automatic t_settle();
    int n0;
    card_khz = 20'd400;
    wr_acc(8'h30, 2'd2, 32'h1);
    check("R11 400kHz stall", resp_cyc - last_wr_cyc, 501);
    card_khz = 20'd100;
    wr_acc(8'h31, 2'd0, 32'h5A);
    check("R11 100kHz stall", resp_cyc - last_wr_cyc, 2001);
    check("R2 byte at lane1", mem[12], 32'h00005A01);
    card_khz = 20'd400;
    wr_acc(8'h04, 2'd1, 32'h0010);
    n0 = wr_cnt;
    wr_acc(8'h0E, 2'd1, 32'h0001);
    check("R9 slow two writes", wr_cnt - n0, 2);
    check("R11 slow flush gap", last_wr_cyc - prev_wr_cyc, 501);
    check("R11 slow cmd resp", resp_cyc - last_wr_cyc, 501);
    check("R6 fresh base block", mem[1], 32'h00000010);
    card_khz = 20'd401;
    wr_acc(8'h30, 2'd2, 32'h2);
    check("R11 401kHz no stall", resp_cyc - last_wr_cyc, 1);
    card_khz = 20'd0;
    wr_acc(8'h30, 2'd2, 32'h3);
    check("R11 zero no stall", resp_cyc - last_wr_cyc, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_narrow_read();
    t_word_write();
    t_half_other();
    t_block();
    t_xfer();
    t_cmd_flush();
    t_stale_cmd();
    t_settle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule